// File: doc/BRIEF.md
# ADC Conversion Phase Sequencer

This block times one 10-bit successive-approximation conversion. It runs in three phases. First the input capacitors charge during a sampling phase. Next a comparison phase resolves the result one bit at a time. A short extra phase closes the conversion. The length of each phase is counted in time units. One time unit passes on each cycle in which the single-cycle time-unit enable is high. A fixed, non-linear table sets the three lengths, indexed by a 2-bit conversion-time field and a 2-bit sample-time field.

The analog comparator and the trial DAC sit outside the block. During comparison the block drives the trial code to the DAC and reads back one comparator bit per decision. It reports busy while a conversion runs. At the end it gives a one-cycle done pulse with the final code. If a start arrives with the reserved conversion-time code, the block ignores the start and flags an error.

Top module: `adc_phase_seq`

## Requirements
- R1: After synchronous reset, busy, sample_en, done and cfg_err are low, and result and dac_code are zero.
- R2: A start is accepted when start_req is high while idle and conv_sel is not 01. From the next cycle, busy stays high until the unit that ends the extra phase. The number of time units counted while busy equals sample+comparison+extra from the table. The table entries are listed as conv_sel/samp_sel = sample/comparison/extra. For conv_sel 00: 00=120/240/28, 01=140/280/16, 10=200/280/52, 11=400/280/44. For conv_sel 11: 00=240/120/52, 01=280/560/28, 10=400/560/100, 11=800/560/52. For conv_sel 10: 00=480/960/100, 01=560/1120/52, 10=800/1120/196, 11=1600/1120/164.
- R3: The sampling phase comes first. sample_en is high for exactly the sample entry's number of time units and rises together with busy.
- R4: The comparison phase is split into 10 equal slots of comparison/10 units each, decided MSB first. The first trial code is 0x200. At the end of each slot the trial bit is kept if cmp_in is 1 and cleared if it is 0, and the next lower bit is set. With cmp_in = (input >= dac_code), the result equals the input code.
- R5: done is high for exactly one cycle, the cycle right after busy falls. result takes the final code on that same cycle and holds it at all other times.
- R6: A start_req with conv_sel 01 while idle starts nothing. cfg_err pulses high on the next cycle, busy stays low, and result is unchanged.
- R7: start_req while busy is ignored. The conv_sel and samp_sel values latched at acceptance govern the whole conversion, even if the inputs change.
- R8: Phase progress happens only on cycles with tu_en high. If tu_en pulses every third cycle, the same unit counts hold and the conversion takes about three times as many clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tu_en | input | 1 | Time-unit enable, one cycle per unit |
| start_req | input | 1 | Conversion start request |
| conv_sel | input | 2 | Conversion-time field (01 reserved) |
| samp_sel | input | 2 | Sample-time field |
| cmp_in | input | 1 | Comparator: 1 when input >= dac_code |
| busy | output | 1 | Conversion in progress |
| sample_en | output | 1 | Sampling phase active |
| done | output | 1 | One-cycle end-of-conversion pulse |
| cfg_err | output | 1 | One-cycle pulse on reserved-code start |
| dac_code | output | 10 | Trial code for the external DAC |
| result | output | 10 | Last completed conversion code |

## Verification
A wrong phase counter or table entry shows up as a changed number of time units while busy or while sample_en is high. Either count is checked at the done pulse that ends the same conversion. A stuck or misordered SAR step gives a wrong result code at that same done pulse, and a wrong first trial shows in the cycle after sampling ends. Latching faults show when a conversion whose inputs changed mid-run ends with the wrong length. A missed reserved-code check shows as busy rising within one cycle of the start.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int LEN_W = 12;
  localparam logic [1:0] CONV_RSVD = 2'b01;

  typedef enum logic [1:0] {PH_IDLE, PH_SAMP, PH_COMP, PH_XTRA} phase_e;

  // slot is the comparison length divided by the 10 bit decisions
  typedef struct packed {
    logic [LEN_W-1:0] samp;
    logic [LEN_W-1:0] slot;
    logic [LEN_W-1:0] xtra;
  } phase_len_t;

  function automatic phase_len_t mk(input int s, input int c, input int x);
    phase_len_t r;
    r.samp = LEN_W'(s);
    r.slot = LEN_W'(c);
    r.xtra = LEN_W'(x);
    return r;
  endfunction

  function automatic phase_len_t lookup(input logic [1:0] cf, input logic [1:0] sf);
    case ({cf, sf})
      4'b0000: return mk(120,  24,  28);
      4'b0001: return mk(140,  28,  16);
      4'b0010: return mk(200,  28,  52);
      4'b0011: return mk(400,  28,  44);
      4'b1100: return mk(240,  12,  52);
      4'b1101: return mk(280,  56,  28);
      4'b1110: return mk(400,  56, 100);
      4'b1111: return mk(800,  56,  52);
      4'b1000: return mk(480,  96, 100);
      4'b1001: return mk(560, 112,  52);
      4'b1010: return mk(800, 112, 196);
      4'b1011: return mk(1600, 112, 164);
      default: return mk(1, 1, 1);
    endcase
  endfunction

endpackage

// File: rtl/adc_unit_timer.sv
module adc_unit_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         last
);

  logic [W-1:0] cnt;

  assign last = tick && run && !clr && (cnt == limit - W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr || last) cnt <= '0;
    else if (tick && run)   cnt <= cnt + W'(1);
  end

  // counter only moves on a time unit
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < limit));

endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         step,
  input  logic         cmp,
  output logic [N-1:0] code,
  output logic         last
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] idx;

  assign last = step && (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      idx  <= '0;
    end else if (init) begin
      code        <= '0;
      code[N-1]   <= 1'b1;
      idx         <= IW'(N-1);
    end else if (step) begin
      code[idx] <= cmp;
      if (idx != '0) begin
        code[idx - IW'(1)] <= 1'b1;
        idx <= idx - IW'(1);
      end
    end
  end

  // the bit under test is always set while it is being decided
  p_trial_set_r4: assert property (@(posedge clk) disable iff (rst)
    step |-> code[idx]);

endmodule

// File: rtl/adc_phase_seq.sv
module adc_phase_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tu_en,
  input  logic                start_req,
  input  logic [1:0]          conv_sel,
  input  logic [1:0]          samp_sel,
  input  logic                cmp_in,
  output logic                busy,
  output logic                sample_en,
  output logic                done,
  output logic                cfg_err,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] result
);

  phase_e           phase;
  logic [1:0]       lat_conv, lat_samp;
  phase_len_t       lens;
  logic [LEN_W-1:0] limit;
  logic             accept, t_last, sar_init, sar_step, sar_last, active;

  assign lens      = lookup(lat_conv, lat_samp);
  assign accept    = start_req && (phase == PH_IDLE) && (conv_sel != CONV_RSVD);
  assign active    = (phase != PH_IDLE);
  assign sample_en = (phase == PH_SAMP);
  assign sar_init  = (phase == PH_SAMP) && t_last;
  assign sar_step  = (phase == PH_COMP) && t_last;

  always_comb begin
    case (phase)
      PH_COMP: limit = lens.slot;
      PH_XTRA: limit = lens.xtra;
      default: limit = lens.samp;
    endcase
  end

  adc_unit_timer #(.W(LEN_W)) u_timer (
    .clk(clk), .rst(rst), .clr(accept), .run(active),
    .tick(tu_en), .limit(limit), .last(t_last)
  );

  adc_sar_reg #(.N(RES_BITS)) u_sar (
    .clk(clk), .rst(rst), .init(sar_init), .step(sar_step),
    .cmp(cmp_in), .code(dac_code), .last(sar_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      lat_conv <= '0;
      lat_samp <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      cfg_err  <= 1'b0;
      result   <= '0;
    end else begin
      done    <= 1'b0;
      cfg_err <= start_req && (phase == PH_IDLE) && (conv_sel == CONV_RSVD);
      case (phase)
        PH_IDLE: if (accept) begin
          lat_conv <= conv_sel;
          lat_samp <= samp_sel;
          phase    <= PH_SAMP;
          busy     <= 1'b1;
        end
        PH_SAMP: if (t_last) phase <= PH_COMP;
        PH_COMP: if (sar_last) phase <= PH_XTRA;
        PH_XTRA: if (t_last) begin
          phase  <= PH_IDLE;
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= dac_code;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_end_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_result_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  p_rsvd_idle_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !busy);

  p_latched_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(lat_conv) && $stable(lat_samp)));

  p_sample_first_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> sample_en);

  p_phase_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && !tu_en) |=> (phase == $past(phase)));

endmodule

// File: tb/adc_phase_seq_tb.sv
module adc_phase_seq_tb;

  typedef struct packed {
    logic [9:0]  res;
    logic [15:0] tot;
    logic [15:0] smp;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tu_en = 1'b0;
  logic       start_req = 1'b0;
  logic [1:0] conv_sel = 2'b00;
  logic [1:0] samp_sel = 2'b00;
  logic       cmp_in;
  logic       busy, sample_en, done, cfg_err;
  logic [9:0] dac_code, result;
  logic [9:0] vin = '0;

  int n_chk = 0, n_fail = 0;
  int tu_div = 1;
  int done_cnt = 0;
  int tu_cnt = 0, s_cnt = 0, b_cnt = 0;
  logic prev_samp = 1'b0, prev_done = 1'b0;
  logic [9:0] last_res = '0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  assign cmp_in = (vin >= dac_code);

  adc_phase_seq u_dut (
    .clk(clk), .rst(rst), .tu_en(tu_en), .start_req(start_req),
    .conv_sel(conv_sel), .samp_sel(samp_sel), .cmp_in(cmp_in),
    .busy(busy), .sample_en(sample_en), .done(done), .cfg_err(cfg_err),
    .dac_code(dac_code), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic void lens(input logic [1:0] c, input logic [1:0] s,
                               output int sm, output int cm, output int ex);
    int t[3][4][3];
    int ci;
    t[0] = '{'{120,240,28}, '{140,280,16}, '{200,280,52}, '{400,280,44}};
    t[1] = '{'{240,120,52}, '{280,560,28}, '{400,560,100}, '{800,560,52}};
    t[2] = '{'{480,960,100}, '{560,1120,52}, '{800,1120,196}, '{1600,1120,164}};
    ci = (c == 2'b00) ? 0 : (c == 2'b11) ? 1 : 2;
    sm = t[ci][s][0];
    cm = t[ci][s][1];
    ex = t[ci][s][2];
  endfunction

  // time-unit enable, one pulse every tu_div cycles
  initial begin
    int d = 0;
    forever begin
      @(negedge clk);
      d = (d + 1 >= tu_div) ? 0 : d + 1;
      tu_en = (d == 0);
    end
  end

  // monitor and scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (busy && tu_en) tu_cnt++;
      if (sample_en && tu_en) s_cnt++;
      if (busy) b_cnt++;
      if (prev_samp && !sample_en && busy)
        chk(dac_code == 10'h200, "R4 first trial MSB", dac_code, 512);
      if (prev_done && done) chk(1'b0, "R5 done width", 2, 1);
      if (done) begin
        exp_t e;
        chk(!busy, "R5 busy low at done", busy, 0);
        if (q.size() == 0) chk(1'b0, "R2 unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          chk(result == e.res, "R4 result", result, e.res);
          chk(tu_cnt == int'(e.tot), "R2 total units", tu_cnt, e.tot);
          chk(s_cnt == int'(e.smp), "R3 sample units", s_cnt, e.smp);
          if (tu_div == 1) chk(b_cnt == int'(e.tot), "R2 busy cycles", b_cnt, e.tot);
          else chk(b_cnt >= tu_div * int'(e.tot) - tu_div + 1 && b_cnt <= tu_div * int'(e.tot),
                   "R8 stretched busy", b_cnt, tu_div * int'(e.tot));
        end
        tu_cnt = 0; s_cnt = 0; b_cnt = 0;
        last_res = result;
        done_cnt++;
      end
      prev_samp = sample_en;
      prev_done = done;
    end
  end

  task automatic run_conv(input logic [1:0] c, input logic [1:0] s, input logic [9:0] v);
    int sm, cm, ex, n;
    exp_t e;
    lens(c, s, sm, cm, ex);
    e.res = v;
    e.tot = 16'(sm + cm + ex);
    e.smp = 16'(sm);
    @(negedge clk);
    vin = v; conv_sel = c; samp_sel = s;
    q.push_back(e);
    n = done_cnt;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    wait (done_cnt == n + 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !sample_en && !done && !cfg_err, "R1 control outputs", busy, 0);
    chk(result == '0 && dac_code == '0, "R1 codes", result, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2/R3/R4 across every legal setting
    run_conv(2'b00, 2'b00, 10'd0);
    run_conv(2'b00, 2'b01, 10'd1023);
    run_conv(2'b00, 2'b10, 10'd512);
    run_conv(2'b00, 2'b11, 10'd511);
    run_conv(2'b11, 2'b00, 10'd341);
    run_conv(2'b11, 2'b01, 10'd682);
    run_conv(2'b11, 2'b10, 10'd1);
    run_conv(2'b11, 2'b11, 10'd1022);
    run_conv(2'b10, 2'b00, 10'd777);
    run_conv(2'b10, 2'b01, 10'd256);
    run_conv(2'b10, 2'b10, 10'd100);
    run_conv(2'b10, 2'b11, 10'd900);

    // R5 result holds after done
    repeat (5) @(negedge clk);
    chk(result == last_res, "R5 result hold", result, last_res);

    // R6 reserved conversion-time code
    conv_sel = 2'b01; samp_sel = 2'b00;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk(cfg_err == 1'b1, "R6 error pulse", cfg_err, 1);
    chk(!busy, "R6 busy low", busy, 0);
    @(negedge clk);
    chk(!cfg_err, "R6 error one cycle", cfg_err, 0);
    repeat (10) @(negedge clk);
    chk(!busy && result == last_res, "R6 nothing started", busy, 0);

    // R7 start while busy ignored, fields latched
    begin
      exp_t e;
      int sm, cm, ex;
      lens(2'b00, 2'b00, sm, cm, ex);
      e.res = 10'd300; e.tot = 16'(sm + cm + ex); e.smp = 16'(sm);
      vin = 10'd300; conv_sel = 2'b00; samp_sel = 2'b00;
      q.push_back(e);
      n = done_cnt;
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      repeat (50) @(negedge clk);
      conv_sel = 2'b10; samp_sel = 2'b11;
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
      wait (done_cnt == n + 1);
      repeat (20) @(negedge clk);
      chk(!busy, "R7 no second conversion", busy, 0);
    end

    // R8 stretched time units
    tu_div = 3;
    run_conv(2'b11, 2'b00, 10'd613);
    run_conv(2'b00, 2'b11, 10'd42);
    tu_div = 1;
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R2 all conversions finished", q.size(), 0);
    finish_up();
  end

endmodule